// File: doc/BRIEF.md
# Chunk Commit Sequencer

Several cores run code in fixed-length chunks without coordination and ask a central sequencer for permission to make each finished chunk visible. Each request comes with two bit signatures that summarise the addresses the chunk read and wrote. The sequencer grants one commit per cycle. When it grants a commit, every other pending chunk whose accesses overlap the winner's writes is squashed so that its core can discard it and run it again. Because every chunk has the same nominal length, the order of grants is the whole record needed for replay. Each grant produces one log record with the core index, plus the real instruction count of any chunk that was cut short by an asynchronous event.

A mode input selects how grants are chosen. In free mode the lowest-numbered eligible core wins. In turn mode the sequencer visits the cores in a fixed rotation and waits for the core whose turn it is. Since that order can be rebuilt without a log, only chunks that were cut short produce a record in this mode.

A requesting core holds `done_i` high until `grant_o` or `squash_o` shows its bit. The core then lowers the request. A core that was granted or squashed in one cycle is never granted in the next cycle, so a request that is dropped one cycle late is harmless.

Top module: `chunk_commit_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `grant_o` and `squash_o` are zero, `log_valid_o`, `log_cut_o`, `log_core_o` and `log_len_o` are zero, and the rotation points at core 0.
- R2: In free mode (`rr_mode_i` = 0) the sequencer grants exactly the lowest-indexed eligible core. A core is eligible when it has `done_i` high and was neither granted nor squashed in the previous cycle. The grant appears on `grant_o` in the cycle after the request is sampled.
- R3: `grant_o` has at most one bit set, and only for a core whose `done_i` was high at the deciding edge.
- R4: A core shown on `grant_o` or `squash_o` in one cycle is not granted in the next cycle, even if its `done_i` is still high.
- R5: When core w is granted, every other eligible core j for which (write signature of w) AND (read signature of j OR write signature of j) is nonzero is flagged on `squash_o` in the same cycle. No other core is flagged.
- R6: `squash_o` is nonzero only in a cycle that also carries a grant, and never flags the granted core.
- R7: In free mode every grant is accompanied in the same cycle by `log_valid_o` = 1, with `log_core_o` holding the granted core's binary index and `log_cut_o` holding that core's `cut_short_i` bit. Without a record, `log_core_o` is zero.
- R8: `log_len_o` carries the granted core's `ins_count_i` field (bits [i*CNT_W +: CNT_W]) when its chunk was cut short. Otherwise it is zero, whatever `ins_count_i` holds.
- R9: In turn mode the sequencer grants only the core at the rotation pointer and waits while that core is not eligible. The pointer starts at 0 and advances by one (wrapping after the last core) after each turn-mode grant. Free-mode grants do not move it.
- R10: In turn mode a grant produces a log record only when the granted chunk was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rr_mode_i | input | 1 | 1 = turn (rotation) mode, 0 = free mode |
| done_i | input | NUM_CORES | Per-core commit request for a finished chunk |
| cut_short_i | input | NUM_CORES | Per-core flag: chunk ended before the nominal length |
| ins_count_i | input | NUM_CORES*CNT_W | Per-core executed instruction count, core i at [i*CNT_W +: CNT_W] |
| rd_sig_i | input | NUM_CORES*SIG_W | Per-core read signature, core i at [i*SIG_W +: SIG_W] |
| wr_sig_i | input | NUM_CORES*SIG_W | Per-core write signature, core i at [i*SIG_W +: SIG_W] |
| grant_o | output | NUM_CORES | One-hot commit grant |
| squash_o | output | NUM_CORES | Cores whose pending chunk must re-execute |
| log_valid_o | output | 1 | Log record present |
| log_core_o | output | IDX_W | Index of the committing core |
| log_cut_o | output | 1 | Logged chunk ended early |
| log_len_o | output | CNT_W | Instruction count of an early-ended chunk |

## Verification
Every result is registered once. Grants, squashes and log records therefore appear in the cycle after the edge that sampled the request. The rotation pointer and the one-cycle block on freshly served cores take effect at the edge after that. The bench drives inputs 1 ns after a rising edge. Its reference model steps on each rising edge, using the inputs held across that edge. Outputs are compared 1 ns after the same edge, which is exactly the cycle in which they are due. A deliberately late core keeps its request up one extra cycle to exercise the blocking rule. Turn-mode phases include stretches in which the current core is idle, to show that the sequencer waits.

// File: rtl/ccs_pkg.sv
// Shared definitions for the chunk commit sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ccs_pkg;

    // Grant selection policy.
    typedef enum logic {
        MODE_FREE = 1'b0,   // lowest eligible index wins
        MODE_TURN = 1'b1    // fixed rotation, wait for the current core
    } ccs_mode_e;

endpackage

// File: rtl/ccs_conflict.sv
// Signature overlap detector: for each core, reports whether the probing
// write signature shares any bit with that core's read or write signature.
// Assumes: signatures are packed per core, core i at [i*SIG_W +: SIG_W].
module ccs_conflict #(
    parameter int NUM_CORES = 4,
    parameter int SIG_W     = 16
) (
    input  logic [SIG_W-1:0]           probe_wr,
    input  logic [NUM_CORES*SIG_W-1:0] rd_sig,
    input  logic [NUM_CORES*SIG_W-1:0] wr_sig,
    output logic [NUM_CORES-1:0]       hit
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [SIG_W-1:0] touched;
        // Union of everything core c accessed.
        assign touched = rd_sig[c*SIG_W +: SIG_W] | wr_sig[c*SIG_W +: SIG_W];
        // Overlap with the committing writes.
        assign hit[c]  = |(probe_wr & touched);
    end

endmodule

// File: rtl/ccs_arbiter.sv
// Commit arbiter: picks at most one eligible core, either the lowest index
// (free mode) or only the core at the rotation pointer (turn mode).
// Assumes: NUM_CORES >= 2; purely combinational.
module ccs_arbiter
    import ccs_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = $clog2(NUM_CORES)
) (
    input  logic [NUM_CORES-1:0] elig,
    input  ccs_mode_e            mode,
    input  logic [IDX_W-1:0]     turn,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output logic [NUM_CORES-1:0] win_onehot
);

    // Select the winner according to the active policy.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        if (mode == MODE_TURN) begin
            win_valid = elig[turn];
            win_idx   = turn;
        end else begin
            for (int i = NUM_CORES - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    win_valid = 1'b1;
                    win_idx   = IDX_W'(i);
                end
            end
        end
    end

    // Decode the winner to a one-hot vector.
    always_comb begin
        win_onehot = win_valid ? (NUM_CORES'(1) << win_idx) : '0;
    end

endmodule

// File: rtl/ccs_turn.sv
// Rotation pointer for turn mode: holds the core whose commit is next and
// steps to the following core (wrapping) each time that core is granted.
// Assumes: NUM_CORES >= 2; synchronous active-low reset.
module ccs_turn #(
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = $clog2(NUM_CORES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] turn
);

    // Step the pointer on each turn-mode grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn <= '0;
        end else if (advance) begin
            turn <= (turn == IDX_W'(NUM_CORES - 1)) ? '0 : turn + 1'b1;
        end
    end

endmodule

// File: rtl/chunk_commit_seq.sv
// Chunk commit sequencer: grants one chunk commit per cycle, squashes pending
// chunks that overlap the winner's writes, and emits a commit-order log.
// Assumes: a core holds done_i until it sees its bit on grant_o or squash_o;
// signatures and counts are stable while done_i is high; NUM_CORES >= 2.
module chunk_commit_seq
    import ccs_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int SIG_W      = 16,
    parameter int CHUNK_LEN  = 1000,
    localparam int IDX_W     = $clog2(NUM_CORES),
    localparam int CNT_W     = $clog2(CHUNK_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rr_mode_i,
    input  logic [NUM_CORES-1:0]       done_i,
    input  logic [NUM_CORES-1:0]       cut_short_i,
    input  logic [NUM_CORES*CNT_W-1:0] ins_count_i,
    input  logic [NUM_CORES*SIG_W-1:0] rd_sig_i,
    input  logic [NUM_CORES*SIG_W-1:0] wr_sig_i,
    output logic [NUM_CORES-1:0]       grant_o,
    output logic [NUM_CORES-1:0]       squash_o,
    output logic                       log_valid_o,
    output logic [IDX_W-1:0]           log_core_o,
    output logic                       log_cut_o,
    output logic [CNT_W-1:0]           log_len_o
);

    ccs_mode_e             mode;
    logic [NUM_CORES-1:0]  elig;
    logic [IDX_W-1:0]      turn;
    logic                  win_valid;
    logic [IDX_W-1:0]      win_idx;
    logic [NUM_CORES-1:0]  win_onehot;
    logic [SIG_W-1:0]      win_wr;
    logic [NUM_CORES-1:0]  hit;
    logic [NUM_CORES-1:0]  kill;
    logic                  win_cut;
    logic [CNT_W-1:0]      win_len;
    logic                  record;

    // Decode the policy input.
    assign mode = rr_mode_i ? MODE_TURN : MODE_FREE;

    // Cores served last cycle sit out one cycle while their request drops.
    assign elig = done_i & ~(grant_o | squash_o);

    ccs_turn #(.NUM_CORES(NUM_CORES)) u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (win_valid && (mode == MODE_TURN)),
        .turn    (turn)
    );

    ccs_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
        .elig       (elig),
        .mode       (mode),
        .turn       (turn),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_onehot (win_onehot)
    );

    // Winner's write signature and chunk details.
    assign win_wr  = wr_sig_i[win_idx*SIG_W +: SIG_W];
    assign win_cut = cut_short_i[win_idx];
    assign win_len = ins_count_i[win_idx*CNT_W +: CNT_W];

    ccs_conflict #(.NUM_CORES(NUM_CORES), .SIG_W(SIG_W)) u_conf (
        .probe_wr (win_wr),
        .rd_sig   (rd_sig_i),
        .wr_sig   (wr_sig_i),
        .hit      (hit)
    );

    // Squash overlapping eligible chunks other than the winner.
    assign kill = win_valid ? (hit & elig & ~win_onehot) : '0;

    // Turn mode logs only early-ended chunks; free mode logs every grant.
    assign record = win_valid && ((mode == MODE_FREE) || win_cut);

    // Register grant, squash and log outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o     <= '0;
            squash_o    <= '0;
            log_valid_o <= 1'b0;
            log_core_o  <= '0;
            log_cut_o   <= 1'b0;
            log_len_o   <= '0;
        end else begin
            grant_o     <= win_onehot;
            squash_o    <= kill;
            log_valid_o <= record;
            log_core_o  <= record ? win_idx : '0;
            log_cut_o   <= record && win_cut;
            log_len_o   <= (record && win_cut) ? win_len : '0;
        end
    end

endmodule

// File: rtl/chunk_commit_seq_chk.sv
// Property checker for the chunk commit sequencer, bound to every instance.
// Assumes: same parameters as the bound instance.
module chunk_commit_seq_chk #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rr_mode_i,
    input logic [NUM_CORES-1:0] done_i,
    input logic [NUM_CORES-1:0] grant_o,
    input logic [NUM_CORES-1:0] squash_o,
    input logic                 log_valid_o,
    input logic [IDX_W-1:0]     log_core_o,
    input logic                 log_cut_o,
    input logic [CNT_W-1:0]     log_len_o
);

    logic             mode_q;
    logic [IDX_W-1:0] exp_turn;

    // Track the mode that was in force at the deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= rr_mode_i;
    end

    // Independent rotation tracker advanced by observed turn-mode grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_turn <= '0;
        end else if ((grant_o != '0) && mode_q) begin
            exp_turn <= (exp_turn == IDX_W'(NUM_CORES - 1)) ? '0 : exp_turn + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (grant_o == '0 && squash_o == '0 && !log_valid_o && log_len_o == '0));

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> ((grant_o & ~$past(done_i)) == '0));

    assert_no_regrant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o | squash_o) != '0) |=> ((grant_o & $past(grant_o | squash_o)) == '0));

    assert_squash_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o != '0) |-> ((squash_o & ~$past(done_i)) == '0));

    assert_squash_with_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o != '0) |-> (grant_o != '0 && (squash_o & grant_o) == '0));

    assert_log_matches_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid_o |-> (grant_o != '0 && grant_o[log_core_o]));

    assert_free_logs_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !mode_q) |-> log_valid_o);

    assert_len_only_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !log_cut_o |-> (log_len_o == '0));

    assert_turn_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && mode_q) |-> (grant_o == (NUM_CORES'(1) << exp_turn)));

    assert_turn_logs_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid_o && mode_q) |-> log_cut_o);

endmodule

bind chunk_commit_seq chunk_commit_seq_chk #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rr_mode_i   (rr_mode_i),
    .done_i      (done_i),
    .grant_o     (grant_o),
    .squash_o    (squash_o),
    .log_valid_o (log_valid_o),
    .log_core_o  (log_core_o),
    .log_cut_o   (log_cut_o),
    .log_len_o   (log_len_o)
);

// File: tb/tb_chunk_commit_seq.sv
`timescale 1ns/1ps
module tb_chunk_commit_seq;

    localparam int NC = 4;
    localparam int SW = 16;
    localparam int CW = 10;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det = 1'b0;
    logic [NC-1:0] req = '0;
    logic [NC-1:0] early = '0;
    logic [CW-1:0] cnt [NC];
    logic [SW-1:0] rd [NC];
    logic [SW-1:0] wr [NC];
    logic [NC*CW-1:0] cnt_flat;
    logic [NC*SW-1:0] rd_flat, wr_flat;

    logic [NC-1:0] grant_o, squash_o;
    logic          log_valid_o, log_cut_o;
    logic [IW-1:0] log_core_o;
    logic [CW-1:0] log_len_o;

    int checks = 0;
    int fails  = 0;
    bit lazy   = 0;
    logic [NC-1:0] drop_next = '0;

    // Reference model state and expectations.
    logic [NC-1:0] m_mask = '0;
    int            m_turn = 0;
    logic [NC-1:0] e_grant = '0, e_squash = '0;
    bit            e_lv = 0, e_cut = 0;
    int            e_core = 0, e_len = 0;
    bit            e_det = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            cnt_flat[i*CW +: CW] = cnt[i];
            rd_flat[i*SW +: SW]  = rd[i];
            wr_flat[i*SW +: SW]  = wr[i];
        end
    end

    chunk_commit_seq dut (
        .clk(clk), .rst_n(rst_n), .rr_mode_i(det), .done_i(req),
        .cut_short_i(early), .ins_count_i(cnt_flat), .rd_sig_i(rd_flat),
        .wr_sig_i(wr_flat), .grant_o(grant_o), .squash_o(squash_o),
        .log_valid_o(log_valid_o), .log_core_o(log_core_o),
        .log_cut_o(log_cut_o), .log_len_o(log_len_o)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Behavioural model of one edge, using the inputs held across it.
    task automatic model_step();
        logic [NC-1:0] el;
        int w;
        e_grant = '0; e_squash = '0; e_lv = 0; e_cut = 0; e_core = 0; e_len = 0;
        e_det = det;
        if (!rst_n) begin
            m_mask = '0; m_turn = 0;
            return;
        end
        el = req & ~m_mask;
        w = -1;
        if (det) begin
            if (el[m_turn]) w = m_turn;
        end else begin
            for (int i = NC - 1; i >= 0; i--) if (el[i]) w = i;
        end
        if (w >= 0) begin
            e_grant[w] = 1'b1;
            for (int j = 0; j < NC; j++)
                if (j != w && el[j] && ((wr[w] & (rd[j] | wr[j])) != '0)) e_squash[j] = 1'b1;
            if (!det || early[w]) begin
                e_lv = 1; e_core = w; e_cut = early[w];
                e_len = early[w] ? int'(cnt[w]) : 0;
            end
            if (det) m_turn = (m_turn + 1) % NC;
        end
        m_mask = e_grant | e_squash;
    endtask

    task automatic compare();
        string gtag;
        gtag = e_det ? "R9 R3 grant" : (lazy ? "R4 R3 grant" : "R2 R3 grant");
        check(grant_o == e_grant, gtag, int'(grant_o), int'(e_grant));
        check(squash_o == e_squash, "R5 R6 squash", int'(squash_o), int'(e_squash));
        check(log_valid_o == e_lv && int'(log_core_o) == e_core && log_cut_o == e_cut,
              e_det ? "R10 log record" : "R7 log record",
              {log_valid_o, log_cut_o, 2'b0, int'(log_core_o)}, {e_lv, e_cut, 2'b0, e_core});
        check(int'(log_len_o) == e_len, "R8 log length", int'(log_len_o), e_len);
    endtask

    // Cores lower requests that were served (one cycle late when lazy).
    task automatic cores_react();
        req = req & ~drop_next;
        if (lazy) drop_next = e_grant | e_squash;
        else begin
            req = req & ~(e_grant | e_squash);
            drop_next = '0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare();
        cores_react();
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic post(input int c, input logic [SW-1:0] r, input logic [SW-1:0] wv,
                        input bit e, input int n);
        req[c] = 1'b1; rd[c] = r; wr[c] = wv; early[c] = e; cnt[c] = CW'(n);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin cnt[i] = '0; rd[i] = '0; wr[i] = '0; end
        #1;
        // R1: outputs idle while reset is held, even with requests present.
        req = '1;
        run(3);
        check(grant_o == '0 && squash_o == '0 && !log_valid_o && log_len_o == '0,
              "R1 reset state", int'(grant_o), 0);
        req = '0;
        rst_n = 1'b1;
        run(2);

        // R2 R7: single request, full-length chunk.
        post(2, 16'h0010, 16'h0020, 0, 999);
        run(3);
        // R2: simultaneous disjoint requests, lowest index first.
        post(1, 16'h0001, 16'h0002, 0, 0);
        post(2, 16'h0004, 16'h0008, 0, 0);
        post(3, 16'h0040, 16'h0080, 0, 0);
        run(5);
        // R8: early-ended chunk logs its count; full chunk logs zero length.
        post(0, 16'h0100, 16'h0200, 1, 437);
        post(1, 16'h0400, 16'h0800, 0, 999);
        run(4);
        // R5: read-write conflict squashes core 1, write-write squashes core 3.
        post(0, 16'h0000, 16'h0001, 0, 0);
        post(1, 16'h0001, 16'h0000, 0, 0);
        post(2, 16'h0000, 16'h0100, 1, 5);
        post(3, 16'h0002, 16'h0100, 0, 0);
        run(5);
        // R4: late-dropping cores must not be granted twice.
        lazy = 1;
        post(0, 16'h0000, 16'h1000, 0, 0);
        post(1, 16'h0000, 16'h2000, 0, 0);
        run(5);
        lazy = 0;
        run(2);
        // R9 R10: turn mode waits for core 0, then rotates; only early chunks logged.
        det = 1;
        post(1, 16'h0000, 16'h0001, 0, 0);
        post(2, 16'h0000, 16'h0002, 1, 12);
        post(3, 16'h0000, 16'h0004, 0, 0);
        run(4);
        post(0, 16'h0000, 16'h0008, 0, 0);
        run(6);

        // Mixed random traffic in both modes.
        for (int k = 0; k < 800; k++) begin
            if (k % 200 == 0) det = ~det;
            for (int i = 0; i < NC; i++) begin
                if (!req[i] && !drop_next[i] && ($urandom % 3 == 0))
                    post(i, SW'(1) << ($urandom % SW), SW'(1) << ($urandom % SW),
                         ($urandom % 4 == 0), $urandom % 1000);
            end
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule